// File: doc/BRIEF.md
# Single-Button Digit Entry Controller

This controller lets an operator program a five-digit timing value using nothing but one clean (already debounced) push button, and then launch the timing run. After reset it first offers a short mode-choice window. A press and release inside that window picks hours-minutes-seconds entry. Letting the window run out picks millisecond entry.

Digits are then entered from the leftmost position to the right. Holding the button counts the active digit upward once per second, and releasing it keeps that value and moves on to the next position. When all five digits are in, the whole value is shown on a six-position multiplexed seven-segment display. The extra rightmost position always reads 0, since the step size is 10 ms or 10 s.

The controller also presents the divide count M for a downstream variable duty-cycle pulse generator. In millisecond mode M is plain decimal. In hours-minutes-seconds mode it is weighted by 6 and 360. One more press blanks the display. Its release fires a one-cycle active-low start trigger and enables the generator until the next reset.

Top module: `digit_entry_ctrl`

## Requirements
- R1: While and right after reset, mode_hms is 0, trig_n is 1, gen_en is 0, every digit is 0, m_val is 0, an is all zero and seg_n is 7'b1111111 (display dark during the mode window).
- R2: A button press followed by its release before WIN_SEC seconds of clock have elapsed since reset sets mode_hms to 1. With no press, the controller leaves the window after WIN_SEC seconds with mode_hms at 0. The mode then stays fixed until reset.
- R3: Entry starts at the leftmost position (an = 6'b100000, an bit 5 is the leftmost, bit 0 the fixed-zero rightmost). The active digit starts at 0 and rises by one for every full CLK_HZ cycles the button stays held.
- R4: A held digit wraps from 9 to 0.
- R5: Releasing the button keeps the active digit and moves the lit position one step right. After the fifth release, entry ends. digits[4*i+3:4*i] carries D(i+1), with D1 the last (rightmost) entered digit.
- R6: In the display phase exactly one an bit is high. Each position stays lit for CLK_HZ/(SCAN_HZ*6) cycles, all six positions are visited, and position 0 always shows the digit 0.
- R7: seg_n is active low, bit 6 = segment a down to bit 0 = segment g. The codes are 0:0000001, 1:1001111, 2:0010010, 3:0000110, 4:1001100, 5:0100100, 6:0100000, 7:0001111, 8:0000000, 9:0000100.
- R8: In millisecond mode m_val = D1 + 10*D2 + 100*D3 + 1000*D4 + 10000*D5.
- R9: In hours-minutes-seconds mode m_val = D1 + 6*(D2 + 10*D3) + 360*(D4 + 10*D5); entry 0,1,2,4,3 gives 507.
- R10: A press in the display phase blanks the display (an = 0, seg_n all ones). Its release drives trig_n low for exactly one cycle and raises gen_en.
- R11: Once gen_en is high, button activity changes no output and gen_en stays high. Only reset brings the controller back to the mode window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn | input | 1 | Debounced push button, high while pressed |
| mode_hms | output | 1 | 1 = hours-minutes-seconds entry, 0 = millisecond entry |
| digits | output | 20 | Five BCD digits, D1 in bits 3:0 up to D5 in bits 19:16 |
| m_val | output | 17 | Divide count M for the pulse generator |
| seg_n | output | 7 | Active-low segments, bit 6 = a to bit 0 = g |
| an | output | 6 | Active-high one-hot position enable, bit 5 leftmost |
| trig_n | output | 1 | Active-low one-cycle start trigger |
| gen_en | output | 1 | Pulse generator enable, held until reset |

## Verification
The assertions assume btn is already synchronous to clk and free of bounce, so that every change on it is one intended press or release. The stimulus drives btn only on falling clock edges and keeps it low for several cycles between presses. Hold times are chosen half a step away from any increment boundary, so no result depends on which cycle a step lands in. The window is also either clearly used or clearly allowed to expire.

// File: rtl/dent_pkg.sv
package dent_pkg;

    localparam int NUM_DIG = 5;
    localparam int NUM_POS = NUM_DIG + 1;
    localparam int POS_W   = $clog2(NUM_DIG);
    localparam int SEL_W   = $clog2(NUM_POS);
    localparam int M_W     = $clog2(10 ** NUM_DIG);

    typedef logic [3:0] bcd_t;
    typedef logic [NUM_DIG-1:0][3:0] digit_vec_t;

    typedef enum logic [2:0] {
        ST_MODE,
        ST_ENTRY,
        ST_SHOW,
        ST_BLANK,
        ST_RUN
    } ctl_state_e;

    typedef struct packed {
        logic             entry;
        logic             show;
        logic [POS_W-1:0] pos;
    } disp_ctl_t;

    function automatic logic [6:0] seg_of(input bcd_t v);
        logic [6:0] s;
        case (v)
            4'd0:    s = 7'b0000001;
            4'd1:    s = 7'b1001111;
            4'd2:    s = 7'b0010010;
            4'd3:    s = 7'b0000110;
            4'd4:    s = 7'b1001100;
            4'd5:    s = 7'b0100100;
            4'd6:    s = 7'b0100000;
            4'd7:    s = 7'b0001111;
            4'd8:    s = 7'b0000000;
            4'd9:    s = 7'b0000100;
            default: s = 7'b1111111;
        endcase
        return s;
    endfunction

    function automatic logic [M_W-1:0] m_calc(input digit_vec_t d, input logic hms);
        int acc;
        if (hms) begin
            acc = int'(d[0]) + 6 * (int'(d[1]) + 10 * int'(d[2]))
                + 360 * (int'(d[3]) + 10 * int'(d[4]));
        end else begin
            acc = 0;
            for (int i = NUM_DIG - 1; i >= 0; i--) begin
                acc = acc * 10 + int'(d[i]);
            end
        end
        return M_W'(acc);
    endfunction

endpackage

// File: rtl/dent_ticker.sv
module dent_ticker #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [W-1:0] cnt;

    assign hit = en && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= hit ? '0 : cnt + 1'b1;
        end
    end

    // R3 / R6: interval counter never passes its limit
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < LIMIT);

endmodule

// File: rtl/dent_fsm.sv
module dent_fsm
    import dent_pkg::*;
#(
    parameter int WIN_TICKS  = 1000,
    parameter int STEP_TICKS = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn,
    output logic       mode_hms,
    output digit_vec_t dig,
    output disp_ctl_t  ctl,
    output logic       trig_n,
    output logic       gen_en
);
    ctl_state_e       st;
    logic             btn_q;
    logic             seen;
    logic [POS_W-1:0] pos;
    logic             rise;
    logic             fall;
    logic             win_hit;
    logic             step_hit;

    assign rise = btn && !btn_q;
    assign fall = !btn && btn_q;

    dent_ticker #(.LIMIT(WIN_TICKS)) u_win (
        .clk(clk), .rst(rst),
        .clr(st != ST_MODE),
        .en (st == ST_MODE),
        .hit(win_hit)
    );

    dent_ticker #(.LIMIT(STEP_TICKS)) u_step (
        .clk(clk), .rst(rst),
        .clr((st != ST_ENTRY) || fall),
        .en ((st == ST_ENTRY) && btn),
        .hit(step_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_MODE;
            btn_q    <= 1'b0;
            seen     <= 1'b0;
            mode_hms <= 1'b0;
            pos      <= POS_W'(NUM_DIG - 1);
            dig      <= '0;
            trig_n   <= 1'b1;
        end else begin
            btn_q  <= btn;
            trig_n <= 1'b1;
            case (st)
                ST_MODE: begin
                    if (rise) seen <= 1'b1;
                    if (fall && seen) begin
                        mode_hms <= 1'b1;
                        st       <= ST_ENTRY;
                    end else if (win_hit && !seen && !btn) begin
                        st <= ST_ENTRY;
                    end
                end
                ST_ENTRY: begin
                    if (step_hit) begin
                        dig[pos] <= (dig[pos] == 4'd9) ? 4'd0 : dig[pos] + 4'd1;
                    end
                    if (fall) begin
                        if (pos == '0) st  <= ST_SHOW;
                        else           pos <= pos - 1'b1;
                    end
                end
                ST_SHOW:  if (rise) st <= ST_BLANK;
                ST_BLANK: if (fall) begin
                    st     <= ST_RUN;
                    trig_n <= 1'b0;
                end
                ST_RUN:   st <= ST_RUN;
                default:  st <= ST_MODE;
            endcase
        end
    end

    assign gen_en    = (st == ST_RUN);
    assign ctl.entry = (st == ST_ENTRY);
    assign ctl.show  = (st == ST_SHOW);
    assign ctl.pos   = pos;

    // R10: trigger is a single-cycle pulse
    p_trig_single_r10: assert property (@(posedge clk) disable iff (rst)
        !trig_n |=> trig_n);
    // R10: trigger only marks the start of the running phase
    p_trig_in_run_r10: assert property (@(posedge clk) disable iff (rst)
        !trig_n |-> gen_en);
    // R11: running phase is left only by reset
    p_run_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        gen_en |=> gen_en);
    // R2: mode frozen once the window is over
    p_mode_locked_r2: assert property (@(posedge clk) disable iff (rst)
        (st != ST_MODE) |=> $stable(mode_hms));
    // R4: held digit wraps from 9 to 0
    p_digit_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ENTRY && step_hit && dig[pos] == 4'd9) |=> (dig[pos] == 4'd0));
    // R11: digits cannot change once running
    p_digits_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        gen_en |=> $stable(dig));

endmodule

// File: rtl/dent_display.sv
module dent_display
    import dent_pkg::*;
#(
    parameter int SCAN_TICKS = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  disp_ctl_t          ctl,
    input  digit_vec_t         dig,
    output logic [NUM_POS-1:0] an,
    output logic [6:0]         seg_n
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_POS - 1);

    logic [SEL_W-1:0] sp_q;
    logic [SEL_W-1:0] sel;
    logic             scan_hit;
    logic             visible;
    bcd_t             val;

    dent_ticker #(.LIMIT(SCAN_TICKS)) u_scan (
        .clk(clk), .rst(rst),
        .clr(!ctl.show),
        .en (ctl.show),
        .hit(scan_hit)
    );

    always_ff @(posedge clk) begin
        if (rst || !ctl.show) begin
            sp_q <= LAST;
        end else if (scan_hit) begin
            sp_q <= (sp_q == '0) ? LAST : sp_q - 1'b1;
        end
    end

    always_comb begin
        visible = ctl.entry || ctl.show;
        sel     = ctl.show ? sp_q : SEL_W'(ctl.pos) + 1'b1;
        val     = (sel == '0) ? 4'd0 : dig[POS_W'(sel - 1'b1)];
        an      = visible ? (NUM_POS'(1) << sel) : '0;
        seg_n   = visible ? seg_of(val) : 7'b1111111;
    end

    // R6: never more than one position lit
    p_an_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(an));
    // R6: scan step moves the lit position
    p_scan_moves_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.show && scan_hit) |=> (!ctl.show || an != $past(an)));

endmodule

// File: rtl/digit_entry_ctrl.sv
module digit_entry_ctrl
    import dent_pkg::*;
#(
    parameter int CLK_HZ  = 200_000_000,
    parameter int WIN_SEC = 5,
    parameter int SCAN_HZ = 30
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 btn,
    output logic                 mode_hms,
    output logic [4*NUM_DIG-1:0] digits,
    output logic [M_W-1:0]       m_val,
    output logic [6:0]           seg_n,
    output logic [NUM_POS-1:0]   an,
    output logic                 trig_n,
    output logic                 gen_en
);
    localparam int STEP_TICKS = CLK_HZ;
    localparam int WIN_TICKS  = CLK_HZ * WIN_SEC;
    localparam int SCAN_RAW   = CLK_HZ / (SCAN_HZ * NUM_POS);
    localparam int SCAN_TICKS = (SCAN_RAW < 1) ? 1 : SCAN_RAW;

    digit_vec_t dig;
    disp_ctl_t  ctl;

    dent_fsm #(
        .WIN_TICKS (WIN_TICKS),
        .STEP_TICKS(STEP_TICKS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .btn     (btn),
        .mode_hms(mode_hms),
        .dig     (dig),
        .ctl     (ctl),
        .trig_n  (trig_n),
        .gen_en  (gen_en)
    );

    dent_display #(
        .SCAN_TICKS(SCAN_TICKS)
    ) u_disp (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .dig  (dig),
        .an   (an),
        .seg_n(seg_n)
    );

    assign digits = dig;
    assign m_val  = m_calc(dig, mode_hms);

    // R10: display dark whenever the generator runs
    p_dark_in_run_r10: assert property (@(posedge clk) disable iff (rst)
        gen_en |-> (an == '0 && seg_n == 7'b1111111));

endmodule

// File: tb/digit_entry_ctrl_bench.sv
`timescale 1ns/1ps
module digit_entry_ctrl_bench;

    localparam int CLK_HZ = 1200;
    localparam int STEP   = CLK_HZ;
    localparam int WIN    = CLK_HZ * 5;
    localparam int SCAN   = CLK_HZ / (30 * 6);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        btn = 1'b0;
    logic        mode_hms;
    logic [19:0] digits;
    logic [16:0] m_val;
    logic [6:0]  seg_n;
    logic [5:0]  an;
    logic        trig_n;
    logic        gen_en;

    int checks = 0;
    int fails  = 0;
    int exp_d [5];

    always #2.5 clk = ~clk;

    digit_entry_ctrl #(.CLK_HZ(CLK_HZ), .WIN_SEC(5), .SCAN_HZ(30)) u_digit_entry_ctrl (
        .clk(clk), .rst(rst), .btn(btn), .mode_hms(mode_hms), .digits(digits),
        .m_val(m_val), .seg_n(seg_n), .an(an), .trig_n(trig_n), .gen_en(gen_en)
    );

    function automatic logic [6:0] exp_seg(input int v);
        case (v)
            0: return 7'b0000001;  1: return 7'b1001111;
            2: return 7'b0010010;  3: return 7'b0000110;
            4: return 7'b1001100;  5: return 7'b0100100;
            6: return 7'b0100000;  7: return 7'b0001111;
            8: return 7'b0000000;  9: return 7'b0000100;
            default: return 7'b1111111;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state(input string req);
        check(mode_hms == 1'b0, req, "mode after reset", mode_hms, 0);
        check(trig_n == 1'b1, req, "trig_n after reset", trig_n, 1);
        check(gen_en == 1'b0, req, "gen_en after reset", gen_en, 0);
        check(digits == 20'd0, req, "digits after reset", digits, 0);
        check(m_val == 17'd0, req, "m after reset", m_val, 0);
        check(an == 6'd0 && seg_n == 7'h7F, req, "display dark", {an, seg_n}, 7'h7F);
    endtask

    task automatic t_hms_select();
        cyc(100);
        btn = 1'b1; cyc(5); btn = 1'b0; cyc(3);
        check(mode_hms == 1'b1, "R2", "hms selected by press", mode_hms, 1);
        check(an == 6'b100000, "R3", "entry starts leftmost", an, 6'b100000);
    endtask

    task automatic t_ms_default();
        cyc(WIN - 50);
        check(an == 6'd0, "R2", "still in mode window", an, 0);
        cyc(100);
        check(mode_hms == 1'b0, "R2", "ms by window expiry", mode_hms, 0);
        check(an == 6'b100000, "R3", "entry starts leftmost", an, 6'b100000);
    endtask

    // idx 0 = leftmost (D5)
    task automatic t_enter_digit(input int k, input int idx);
        int p = 4 - idx;
        int got;
        btn = 1'b1;
        cyc(k * STEP + STEP / 2);
        got = int'(digits[4*p +: 4]);
        check(got == k % 10, (k > 9) ? "R4" : "R3", "held digit value", got, k % 10);
        check(seg_n == exp_seg(k % 10), "R7", "entry segments", seg_n, exp_seg(k % 10));
        exp_d[p] = k % 10;
        btn = 1'b0;
        cyc(3);
        if (idx < 4) begin
            check(an == (6'b100000 >> (idx + 1)), "R5", "enable moved right", an,
                  6'b100000 >> (idx + 1));
            check(int'(digits[4*p +: 4]) == k % 10, "R5", "digit kept", digits[4*p +: 4], k % 10);
        end
    endtask

    task automatic t_show_scan();
        logic [5:0] prev;
        logic [5:0] seen;
        int run, bad_hot, bad_seg, bad_run, changes, pos, v;
        prev = an; seen = '0; run = 0; bad_hot = 0; bad_seg = 0; bad_run = 0; changes = 0;
        for (int i = 0; i < 13 * SCAN; i++) begin
            if (!$onehot(an)) bad_hot++;
            else begin
                pos = $clog2(an);
                seen |= an;
                v = (pos == 0) ? 0 : exp_d[pos - 1];
                if (seg_n != exp_seg(v)) bad_seg++;
            end
            if (an != prev) begin
                if (changes > 0 && run != SCAN) bad_run++;
                changes++;
                run = 1;
            end else run++;
            prev = an;
            cyc(1);
        end
        check(bad_hot == 0, "R6", "one-hot samples", bad_hot, 0);
        check(seen == 6'b111111, "R6", "all positions scanned", seen, 6'b111111);
        check(bad_run == 0 && changes >= 6, "R6", "scan dwell", bad_run, 0);
        check(bad_seg == 0, "R7", "scanned segments incl. fixed zero", bad_seg, 0);
    endtask

    task automatic t_start();
        int lows = 0;
        btn = 1'b1; cyc(4);
        check(an == 6'd0 && seg_n == 7'h7F, "R10", "blank on press", {an, seg_n}, 7'h7F);
        check(trig_n == 1'b1 && gen_en == 1'b0, "R10", "no start while held",
              {trig_n, gen_en}, 2'b10);
        btn = 1'b0;
        for (int i = 0; i < 6; i++) begin
            cyc(1);
            if (!trig_n) lows++;
        end
        check(lows == 1, "R10", "trigger width", lows, 1);
        check(gen_en == 1'b1, "R10", "generator enabled", gen_en, 1);
    endtask

    task automatic t_run_ignore(input int exp_m);
        logic [19:0] d0 = digits;
        logic        m0 = mode_hms;
        int bad = 0;
        for (int i = 0; i < 3; i++) begin
            btn = 1'b1;
            for (int j = 0; j < 20; j++) begin
                cyc(1);
                if (!gen_en || !trig_n || an != 0 || seg_n != 7'h7F) bad++;
            end
            btn = 1'b0;
            for (int j = 0; j < 20; j++) begin
                cyc(1);
                if (!gen_en || !trig_n || an != 0 || seg_n != 7'h7F) bad++;
            end
        end
        check(bad == 0, "R11", "outputs unchanged by presses", bad, 0);
        check(digits == d0 && mode_hms == m0 && int'(m_val) == exp_m, "R11",
              "value kept while running", m_val, exp_m);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired: got 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cyc(5);
        t_reset_state("R1");
        rst = 1'b0;
        cyc(1);
        t_reset_state("R1");

        // hours-minutes-seconds run: 01:24:30
        t_hms_select();
        t_enter_digit(0, 0);
        t_enter_digit(1, 1);
        t_enter_digit(2, 2);
        t_enter_digit(4, 3);
        t_enter_digit(3, 4);
        check(digits == 20'h01243, "R5", "five digits stored", digits, 20'h01243);
        check(m_val == 17'd507, "R9", "hms count", m_val, 507);
        t_show_scan();
        t_start();
        t_run_ignore(507);

        rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
        t_reset_state("R11");

        // millisecond run with a wrapped digit
        t_ms_default();
        t_enter_digit(3, 0);
        t_enter_digit(0, 1);
        t_enter_digit(11, 2);
        t_enter_digit(0, 3);
        t_enter_digit(7, 4);
        check(m_val == 17'd30107, "R8", "ms count", m_val, 30107);
        t_show_scan();
        t_start();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule